// File: doc/BRIEF.md
# GPIO Level Interrupt Router

This block turns the levels on a 32-bit general-purpose input bus into interrupt requests. It has eight interrupt slots. Slot k always looks at bit k of one byte-wide pin group. Each slot chooses which of the four groups it watches, and it also chooses whether it fires while that pin is high or while it is low. The block first passes the pins through a two-stage synchroniser. After that, each slot evaluates its level condition every cycle. A slot whose condition holds sets a sticky pending latch.

Software drives the block through a small register port that is written synchronously and read combinationally. The registers cover the following:

- the packed per-slot trigger codes;
- the packed per-slot group choices;
- an enable mask;
- a write-one-to-clear acknowledge;
- read-only raw and masked pending status.

The block drives one combined interrupt line. That line is a registered OR of all enabled pending slots.

Top module: `pin_irq_router`

## Requirements
- R1: After reset the trigger, group and enable registers read 0, raw and masked status read 0, and `irq_o` is 0.
- R2: The trigger register (offset 0) holds a 3-bit code per slot, with slot k in bits [3k+2:3k], 24 bits in total. Bits above 23 read 0. Code 1 means active while high and code 2 means active while low.
- R3: The group register (offset 1) holds a 4-bit value g per slot, with slot k in bits [4k+3:4k]. Slot k observes pin 8g+k. A value of 4 or above observes a constant low.
- R4: A slot with code 1 sets its pending bit while its observed pin is high. The bit appears in raw status 3 clock edges after the pin changes: two synchroniser flops, then the pending latch.
- R5: A slot with code 2 sets its pending bit while its observed pin is low.
- R6: Codes 0 and 3 through 7 never set a pending bit, whatever the pin level.
- R7: A pending bit stays set after its level condition goes away, until it is acknowledged.
- R8: Writing the acknowledge register (offset 3) with bit k set clears slot k's pending bit, but only if its level condition is false at that time. If the condition is still true, the bit stays set. Bits written as 0 have no effect.
- R9: The enable mask (offset 2, 8 bits) gates status. Masked status (offset 5) reads raw status (offset 4) ANDed with the mask.
- R10: `irq_o` is registered. It equals the OR of masked status one clock edge later.
- R11: The acknowledge offset reads 0. Offsets 6 and 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 32 | Asynchronous GPIO input levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on the offset) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets the following cases, each with the failure it would expose:

- **Group routing.** Decoy pins sit in the same byte as a watched pin but in another slot's column. A mux that indexes the wrong bit or the wrong group would report those pins instead of the intended ones.
- **Out-of-range groups.** An out-of-range group value paired with a low trigger must fire. A design that wrapped the index into a real group would stay quiet.
- **Acknowledge semantics.** These are checked both while the level condition still holds and with partial masks. A latch that cleared unconditionally, or that treated 0 bits as clears, would lose a live request or drop a neighbour.
- **Cycle timing.** Exact latency is checked at each edge. A missing synchroniser stage, or an unregistered interrupt line, would show its output one cycle early.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int NUM_SLOTS = 8;
    localparam int TRIG_W    = 3;
    localparam int GSEL_W    = 4;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 32;
    localparam int TRIGS_W   = NUM_SLOTS * TRIG_W;
    localparam int GSELS_W   = NUM_SLOTS * GSEL_W;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_OFF  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        ADR_TRIG   = 3'd0,
        ADR_GSEL   = 3'd1,
        ADR_MASK   = 3'd2,
        ADR_ACK    = 3'd3,
        ADR_RAW    = 3'd4,
        ADR_MASKED = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [TRIGS_W-1:0]   trig;
        logic [GSELS_W-1:0]   gsel;
        logic [NUM_SLOTS-1:0] mask;
    } cfg_t;

    // Level condition for one slot: only the two level codes can ever hit.
    function automatic logic level_hit(input logic [TRIG_W-1:0] code,
                                       input logic pin);
        logic hit;
        hit = 1'b0;
        if (code == TRIG_HIGH) hit = pin;
        else if (code == TRIG_LOW) hit = !pin;
        return hit;
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pin_irq_slot.sv
module pin_irq_slot
    import pin_irq_pkg::*;
#(
    parameter int NGROUPS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NGROUPS-1:0] col,
    input  logic [TRIG_W-1:0]  trig,
    input  logic [GSEL_W-1:0]  gsel,
    input  logic               ack,
    output logic               pend
);
    logic obs;
    logic cond;
    logic pend_q;

    // Group select: values beyond the last group observe a constant low.
    always_comb begin
        obs = 1'b0;
        for (int g = 0; g < NGROUPS; g++) begin
            if (gsel == GSEL_W'(g)) obs = col[g];
        end
    end

    assign cond = level_hit(trig, obs);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= cond | (pend_q & ~ack);
    end

    assign pend = pend_q;

    assert_level_sets_R4: assert property (@(posedge clk) disable iff (rst)
        cond |=> pend_q);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ack) |=> pend_q);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && !cond) |=> !pend_q);

    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (trig != TRIG_HIGH && trig != TRIG_LOW && !pend_q) |=> !pend_q);
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SLOTS-1:0] raw,
    output cfg_t                 cfg,
    output logic [NUM_SLOTS-1:0] ack,
    output logic [NUM_SLOTS-1:0] masked,
    output logic [DATA_W-1:0]    rdata
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            case (addr)
                ADR_TRIG: cfg_q.trig <= wdata[TRIGS_W-1:0];
                ADR_GSEL: cfg_q.gsel <= wdata[GSELS_W-1:0];
                ADR_MASK: cfg_q.mask <= wdata[NUM_SLOTS-1:0];
                default:  ;
            endcase
        end
    end

    assign cfg    = cfg_q;
    assign ack    = (wr && addr == ADR_ACK) ? wdata[NUM_SLOTS-1:0] : '0;
    assign masked = raw & cfg_q.mask;

    always_comb begin
        case (addr)
            ADR_TRIG:   rdata = DATA_W'(cfg_q.trig);
            ADR_GSEL:   rdata = DATA_W'(cfg_q.gsel);
            ADR_MASK:   rdata = DATA_W'(cfg_q.mask);
            ADR_RAW:    rdata = DATA_W'(raw);
            ADR_MASKED: rdata = DATA_W'(masked);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router
    import pin_irq_pkg::*;
#(
    parameter int PIN_W       = 32,
    parameter int GROUP_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_W-1:0]  pins_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int NGROUPS = PIN_W / GROUP_W;

    logic [PIN_W-1:0]     pins_s;
    cfg_t                 cfg;
    logic [NUM_SLOTS-1:0] ack_vec;
    logic [NUM_SLOTS-1:0] pend_raw;
    logic [NUM_SLOTS-1:0] pend_masked;
    logic                 irq_q;

    pin_irq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_i),
        .q   (pins_s)
    );

    pin_irq_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr_i),
        .addr   (reg_addr_i),
        .wdata  (reg_wdata_i),
        .raw    (pend_raw),
        .cfg    (cfg),
        .ack    (ack_vec),
        .masked (pend_masked),
        .rdata  (reg_rdata_o)
    );

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic [NGROUPS-1:0] col;
        for (genvar g = 0; g < NGROUPS; g++) begin : g_col
            assign col[g] = pins_s[g*GROUP_W + k];
        end
        pin_irq_slot #(.NGROUPS(NGROUPS)) u_slot (
            .clk  (clk),
            .rst  (rst),
            .col  (col),
            .trig (cfg.trig[k*TRIG_W +: TRIG_W]),
            .gsel (cfg.gsel[k*GSEL_W +: GSEL_W]),
            .ack  (ack_vec[k]),
            .pend (pend_raw[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pend_masked;
    end

    assign irq_o = irq_q;

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|pend_masked)));
endmodule

// File: tb/test_pin_irq_router.sv
module test_pin_irq_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pins = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    pin_irq_router i_pin_irq_router (
        .clk         (clk),
        .rst         (rst),
        .pins_i      (pins),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    localparam logic [2:0] A_TRIG = 3'd0, A_GSEL = 3'd1, A_MASK = 3'd2,
                           A_ACK  = 3'd3, A_RAW  = 3'd4, A_MSK  = 3'd5;

    typedef struct packed {
        logic [31:0] pins;
        logic [23:0] trig;
        logic [31:0] gsel;
        logic [7:0]  mask;
        logic [7:0]  raw;
        logic [7:0]  masked;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h000000A5, 24'h249249, 32'h00000000, 8'hFF, 8'hA5, 8'hA5},
        '{32'h0000A500, 24'h249249, 32'h00000000, 8'hFF, 8'h00, 8'h00},
        '{32'h0000A500, 24'h249249, 32'h11111111, 8'h0F, 8'hA5, 8'h05},
        '{32'h3C000000, 24'h492492, 32'h33333333, 8'hFF, 8'hC3, 8'hC3},
        '{32'hFFFFFFFF, 24'h492492, 32'h55555555, 8'h00, 8'hFF, 8'h00},
        '{32'hFFFFFFFF, 24'h000000, 32'h00000000, 8'hFF, 8'h00, 8'h00},
        '{32'hFFFFFFFF, 24'h6DB6DB, 32'h00000000, 8'hFF, 8'h00, 8'h00},
        '{32'h000000FF, 24'hFFFFFF, 32'h00000000, 8'hFF, 8'h00, 8'h00},
        '{32'h000000F0, 24'h451451, 32'h00000000, 8'hF0, 8'h5A, 8'h50},
        '{32'h80400202, 24'h249249, 32'h32103210, 8'hFF, 8'hC2, 8'hC2}
    };
    localparam string VTAG [NV] = '{"R4", "R3", "R3 R9", "R5", "R3 R5 R9",
                                    "R6", "R6", "R6", "R4 R5 R9", "R3"};

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        wait_neg(4);
        rst = 1'b0;

        // R1: reset state
        rd(A_TRIG, d); check("R1 trig", d, 32'h0);
        rd(A_GSEL, d); check("R1 gsel", d, 32'h0);
        rd(A_MASK, d); check("R1 mask", d, 32'h0);
        rd(A_RAW,  d); check("R1 raw",  d, 32'h0);
        rd(A_MSK,  d); check("R1 masked", d, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // Vector table: steady-state routing and level decoding
        for (int v = 0; v < NV; v++) begin
            wr(A_TRIG, 32'h0);
            @(negedge clk);
            pins = VECS[v].pins;
            wait_neg(4);
            wr(A_ACK, 32'hFF);
            wr(A_GSEL, VECS[v].gsel);
            wr(A_MASK, {24'h0, VECS[v].mask});
            wr(A_TRIG, {8'h0, VECS[v].trig});
            wait_neg(2);
            rd(A_RAW, d); check({VTAG[v], " raw"}, d, {24'h0, VECS[v].raw});
            rd(A_MSK, d); check({VTAG[v], " R9 masked"}, d, {24'h0, VECS[v].masked});
            check("R10 irq", {31'h0, irq}, {31'h0, |VECS[v].masked});
        end

        // Clean slate: slot 0 high-level, group 0, enabled
        wr(A_TRIG, 32'h0);
        @(negedge clk); pins = '0;
        wait_neg(4);
        wr(A_ACK, 32'hFF);
        wr(A_GSEL, 32'h0);
        wr(A_MASK, 32'h01);
        wr(A_TRIG, 32'h1);
        wait_neg(3);

        // R4: latency of three edges, R10: irq one more edge
        @(negedge clk); reg_addr = A_RAW; pins = 32'h1;
        @(negedge clk); #1; check("R4 latency edge1", reg_rdata, 32'h0);
        @(negedge clk); #1; check("R4 latency edge2", reg_rdata, 32'h0);
        @(negedge clk); #1; check("R4 latency edge3", reg_rdata, 32'h1);
        check("R10 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk); #1; check("R10 irq edge4", {31'h0, irq}, 32'h1);

        // R7: sticky after pin returns low
        pins = '0;
        wait_neg(5);
        rd(A_RAW, d); check("R7 sticky", d, 32'h1);
        check("R7 irq held", {31'h0, irq}, 32'h1);

        // R8: acknowledge clears when condition is false
        wr(A_ACK, 32'h1);
        rd(A_RAW, d); check("R8 ack clears", d, 32'h0);
        check("R10 irq drops", {31'h0, irq}, 32'h0);

        // R8: acknowledge while condition still true keeps the bit
        @(negedge clk); pins = 32'h1;
        wait_neg(4);
        wr(A_ACK, 32'h1);
        rd(A_RAW, d); check("R8 ack while active", d, 32'h1);

        // R8: zero bits of acknowledge have no effect
        wr(A_TRIG, 32'h41);
        @(negedge clk); pins = 32'h5;
        wait_neg(4);
        @(negedge clk); pins = 32'h0;
        wait_neg(4);
        wr(A_ACK, 32'h04);
        rd(A_RAW, d); check("R8 partial ack", d, 32'h01);

        // R9/R10: mask gating
        wr(A_MASK, 32'h0);
        rd(A_MSK, d); check("R9 mask off", d, 32'h0);
        @(negedge clk); #1; check("R10 irq masked", {31'h0, irq}, 32'h0);
        rd(A_RAW, d); check("R9 raw unaffected", d, 32'h01);

        // R2/R3/R11: register widths and map
        wr(A_TRIG, 32'hFFFFFFFF);
        rd(A_TRIG, d); check("R2 trig width", d, 32'h00FFFFFF);
        wr(A_GSEL, 32'hA5A5A5A5);
        rd(A_GSEL, d); check("R3 gsel readback", d, 32'hA5A5A5A5);
        wr(A_MASK, 32'h1FF);
        rd(A_MASK, d); check("R9 mask width", d, 32'h000000FF);
        rd(A_ACK, d); check("R11 ack reads zero", d, 32'h0);
        wr(3'd7, 32'hFFFFFFFF);
        rd(3'd7, d); check("R11 unmapped", d, 32'h0);
        rd(A_GSEL, d); check("R11 unmapped write ignored", d, 32'hA5A5A5A5);

        finish_run();
    end
endmodule